// File: doc/BRIEF.md
# Matrix Keypad Scanner with Debounce

The block scans a switch matrix of up to `MAX_ROWS` rows by `MAX_COLS` columns (8 by 10, 80 keys, by default) and turns key activity into debounced press and release events. Each key shorts one row line to one column line. Row inputs are pulled up outside the block. While nothing is happening, every enabled column is driven low, so any key press pulls its row low. A low on an enabled row wakes the scanner. It then walks a single low column across the enabled columns, waiting a few clocks after each column change before it samples the rows. This builds a full snapshot of which keys are down.

Each key has its own counter clocked by a 1 ms tick input, so the debounce interval does not depend on the clock frequency. A key must hold its new level for `DEBOUNCE_MS` ticks before its change is reported. The report is a one-cycle strobe with a byte. Bit 7 of the byte tells press from release, and bits 6:0 carry a one-based, row-major key code. Scanning continues while any key is down or any change is still being timed. The block falls back to the quiet all-columns-low state once every key has been reported released.

Top module: `keypad_scanner`

## Requirements
- R1: After reset no event is emitted, and `col_out` shows the idle pattern for the configured column count.
- R2: While idle, each column whose index is below `num_cols` is driven low and every other column is driven high. Rows at or above `num_rows` never start a scan.
- R3: While scanning, exactly one column is low and its index is below `num_cols`. The low starts at column 0 on leaving idle and steps by one, wrapping from `num_cols-1` back to 0.
- R4: `evt_data[6:0]` holds the key code row*`MAX_COLS` + column + 1, so row 0 column 0 is code 1 and, by default, row 7 column 9 is code 80.
- R5: A change is reported at the `DEBOUNCE_MS`-th `ms_tick` counted after the first full scan that sees it, and never at an earlier tick. A scan that sees the key back at its reported level restarts the count.
- R6: `evt_data[7]` is 1 for a press and 0 for a release. Releases are debounced exactly like presses.
- R7: Several keys may be down at once and each gets its own event. Events that become due together leave on consecutive cycles, lowest code first, and each as a single-cycle `evt_valid` pulse.
- R8: A key in a row at or above `num_rows`, or in a column at or above `num_cols`, never produces an event.
- R9: Scanning continues while any key is held or awaiting report. Once all keys are reported released, `col_out` returns to the idle pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_in | input | MAX_ROWS | Row lines, pulled up externally; low means a closed key in a low column |
| num_rows | input | $clog2(MAX_ROWS+1) | Number of enabled rows (clamped to MAX_ROWS) |
| num_cols | input | $clog2(MAX_COLS+1) | Number of enabled columns (clamped to MAX_COLS) |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| col_out | output | MAX_COLS | Column drive levels |
| evt_valid | output | 1 | Event strobe, one cycle per event |
| evt_data | output | 8 | Bit 7 press flag, bits 6:0 key code |

## Verification
The bench builds the block with 3 rows, 4 columns, a 3-tick debounce and a 4-cycle settle. At that size every key of the full matrix, and of a reduced 2-by-3 setting, can be pressed and released one at a time. Each resulting code is compared with row*4+col+1. The short debounce lets each event be pinned to the exact tick on which it must appear, one tick after the last quiet one. It also keeps the bounce restart, simultaneous presses and disabled-row and disabled-column keys affordable to cover.

// File: rtl/kps_pkg.sv
package kps_pkg;

  typedef enum logic [1:0] {
    SC_IDLE   = 2'd0,
    SC_SETTLE = 2'd1,
    SC_SAMPLE = 2'd2
  } kps_scan_e;

  // One-based, row-major key code; stride is the physical column count.
  function automatic logic [6:0] kps_code(int unsigned row, int unsigned col,
                                          int unsigned stride);
    return 7'(row * stride + col + 1);
  endfunction

endpackage

// File: rtl/kps_col_walker.sv
module kps_col_walker
  import kps_pkg::*;
#(
  parameter int NR     = 8,
  parameter int NC     = 10,
  parameter int SETTLE = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NR-1:0]               row_low,
  input  logic [$clog2(NC+1)-1:0]     eff_cols,
  input  logic                        keep_alive,
  output logic [NC-1:0]               col_out,
  output logic [NR*NC-1:0]            raw_keys,
  output logic                        sweep_done
);
  localparam int CW   = $clog2(NC + 1);
  localparam int CIW  = (NC > 1) ? $clog2(NC) : 1;
  localparam int SW   = $clog2(SETTLE + 1);
  localparam int NK   = NR * NC;

  kps_scan_e           state;
  logic [CIW-1:0]      col_idx;
  logic [SW-1:0]       settle_cnt;
  logic [NK-1:0]       raw_q;
  logic [NK-1:0]       next_raw;
  logic                sweep_q;
  logic                any_row;
  logic                last_col;
  logic                wake;
  logic [NC-1:0]       idle_cols;

  assign any_row  = |row_low;
  assign last_col = (CW'(col_idx) == eff_cols - CW'(1));
  assign wake     = (eff_cols != '0) && (any_row || keep_alive);

  for (genvar c = 0; c < NC; c++) begin : g_idle
    assign idle_cols[c] = !(CW'(c) < eff_cols);
  end

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      if (state == SC_IDLE) col_out[c] = idle_cols[c];
      else                  col_out[c] = (CIW'(c) != col_idx);
    end
  end

  // Merge the rows seen under the active column into the snapshot.
  always_comb begin
    next_raw = raw_q;
    for (int r = 0; r < NR; r++) begin
      for (int c = 0; c < NC; c++) begin
        if (CIW'(c) == col_idx) next_raw[r*NC + c] = row_low[r];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SC_IDLE;
      col_idx    <= '0;
      settle_cnt <= '0;
      raw_q      <= '0;
      sweep_q    <= 1'b0;
    end else begin
      sweep_q <= 1'b0;
      case (state)
        SC_IDLE: begin
          if (wake) begin
            state      <= SC_SETTLE;
            col_idx    <= '0;
            settle_cnt <= '0;
          end
        end
        SC_SETTLE: begin
          if (settle_cnt == SW'(SETTLE - 1)) state <= SC_SAMPLE;
          else settle_cnt <= settle_cnt + SW'(1);
        end
        SC_SAMPLE: begin
          raw_q      <= next_raw;
          settle_cnt <= '0;
          if (last_col) begin
            sweep_q <= 1'b1;
            col_idx <= '0;
            if ((|next_raw) || keep_alive) state <= SC_SETTLE;
            else                           state <= SC_IDLE;
          end else begin
            col_idx <= col_idx + CIW'(1);
            state   <= SC_SETTLE;
          end
        end
        default: state <= SC_IDLE;
      endcase
    end
  end

  assign raw_keys   = raw_q;
  assign sweep_done = sweep_q;

  // R3
  one_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != SC_IDLE) |-> ($countones(col_out) == NC - 1))
    else $error("more or fewer than one column low during scan");

  // R3
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SC_SAMPLE && !last_col) |=> (col_idx == $past(col_idx) + CIW'(1)))
    else $error("column walk skipped a column");

  // R3
  sweep_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |-> ($past(CW'(col_idx)) == eff_cols - CW'(1)))
    else $error("sweep ended before the last enabled column");

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SC_IDLE && !any_row && !keep_alive) |=> (state == SC_IDLE))
    else $error("scan started without row activity");
endmodule

// File: rtl/kps_debounce.sv
module kps_debounce #(
  parameter int NK  = 80,
  parameter int DEB = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NK-1:0] raw,
  input  logic          sweep_done,
  input  logic          ms_tick,
  input  logic [NK-1:0] grant,
  output logic [NK-1:0] key_state,
  output logic [NK-1:0] pending,
  output logic          keep_alive
);
  localparam int CNTW = $clog2(DEB + 1);

  logic [NK-1:0] differs;

  for (genvar k = 0; k < NK; k++) begin : g_key
    logic            st;
    logic            df;
    logic            pd;
    logic [CNTW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st  <= 1'b0;
        df  <= 1'b0;
        pd  <= 1'b0;
        cnt <= '0;
      end else begin
        if (grant[k]) pd <= 1'b0;
        if (sweep_done) df <= raw[k] ^ st;
        if (sweep_done && (raw[k] == st)) begin
          cnt <= '0;
        end else if (ms_tick && df) begin
          if (cnt == CNTW'(DEB - 1)) begin
            st  <= ~st;
            df  <= 1'b0;
            cnt <= '0;
            pd  <= 1'b1;
          end else begin
            cnt <= cnt + CNTW'(1);
          end
        end
      end
    end

    assign key_state[k] = st;
    assign differs[k]   = df;
    assign pending[k]   = pd;
  end

  assign keep_alive = (|key_state) || (|differs) || (|pending);

  // R5
  flip_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_state != $past(key_state)) |-> $past(ms_tick))
    else $error("debounced state changed without a millisecond tick");

  // R7
  grant_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~pending) == '0))
    else $error("grant to a key with nothing to report");
endmodule

// File: rtl/kps_event_arb.sv
module kps_event_arb
  import kps_pkg::*;
#(
  parameter int NR = 8,
  parameter int NC = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NR*NC-1:0] pending,
  input  logic [NR*NC-1:0] key_state,
  output logic [NR*NC-1:0] grant,
  output logic             evt_valid,
  output logic [7:0]       evt_data
);
  localparam int NK = NR * NC;
  localparam int KW = (NK > 1) ? $clog2(NK) : 1;

  logic [KW-1:0] sel;
  logic          found;

  // Lowest pending index wins.
  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int k = NK - 1; k >= 0; k--) begin
      if (pending[k]) begin
        sel   = KW'(k);
        found = 1'b1;
      end
    end
  end

  for (genvar k = 0; k < NK; k++) begin : g_grant
    assign grant[k] = found && (sel == KW'(k));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_valid <= 1'b0;
      evt_data  <= '0;
    end else begin
      evt_valid <= found;
      if (found)
        evt_data <= {key_state[sel],
                     kps_code(int'(sel) / NC, int'(sel) % NC, NC)};
    end
  end

  // R7
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant))
    else $error("more than one key granted");

  // R4
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_data[6:0] != 7'd0 && int'(evt_data[6:0]) <= NK))
    else $error("key code out of range");

  // R7
  evt_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> $past(|pending))
    else $error("event without a pending key");
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
  import kps_pkg::*;
#(
  parameter int MAX_ROWS      = 8,
  parameter int MAX_COLS      = 10,
  parameter int DEBOUNCE_MS   = 25,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [MAX_ROWS-1:0]             row_in,
  input  logic [$clog2(MAX_ROWS+1)-1:0]   num_rows,
  input  logic [$clog2(MAX_COLS+1)-1:0]   num_cols,
  input  logic                            ms_tick,
  output logic [MAX_COLS-1:0]             col_out,
  output logic                            evt_valid,
  output logic [7:0]                      evt_data
);
  // Key codes are 7 bits wide: MAX_ROWS*MAX_COLS must stay at or below 127.
  localparam int RW = $clog2(MAX_ROWS + 1);
  localparam int CW = $clog2(MAX_COLS + 1);
  localparam int NK = MAX_ROWS * MAX_COLS;

  logic [RW-1:0]       eff_rows;
  logic [CW-1:0]       eff_cols;
  logic [MAX_ROWS-1:0] row_mask;
  logic [NK-1:0]       key_en;
  logic [MAX_ROWS-1:0] row_s1, row_s2;
  logic [MAX_ROWS-1:0] row_low;
  logic [NK-1:0]       raw_keys;
  logic [NK-1:0]       raw_masked;
  logic                sweep_done;
  logic                keep_alive;
  logic [NK-1:0]       key_state;
  logic [NK-1:0]       pending;
  logic [NK-1:0]       grant;

  assign eff_rows = (num_rows > RW'(MAX_ROWS)) ? RW'(MAX_ROWS) : num_rows;
  assign eff_cols = (num_cols > CW'(MAX_COLS)) ? CW'(MAX_COLS) : num_cols;

  for (genvar r = 0; r < MAX_ROWS; r++) begin : g_row
    assign row_mask[r] = (RW'(r) < eff_rows);
    for (genvar c = 0; c < MAX_COLS; c++) begin : g_col
      assign key_en[r*MAX_COLS + c] = row_mask[r] && (CW'(c) < eff_cols);
    end
  end

  // Row lines come from the pad: two-stage synchronizer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_s1 <= '1;
      row_s2 <= '1;
    end else begin
      row_s1 <= row_in;
      row_s2 <= row_s1;
    end
  end

  assign row_low    = ~row_s2 & row_mask;
  assign raw_masked = raw_keys & key_en;

  kps_col_walker #(
    .NR     (MAX_ROWS),
    .NC     (MAX_COLS),
    .SETTLE (SETTLE_CYCLES)
  ) u_walker (
    .clk        (clk),
    .rst_n      (rst_n),
    .row_low    (row_low),
    .eff_cols   (eff_cols),
    .keep_alive (keep_alive),
    .col_out    (col_out),
    .raw_keys   (raw_keys),
    .sweep_done (sweep_done)
  );

  kps_debounce #(
    .NK  (NK),
    .DEB (DEBOUNCE_MS)
  ) u_debounce (
    .clk        (clk),
    .rst_n      (rst_n),
    .raw        (raw_masked),
    .sweep_done (sweep_done),
    .ms_tick    (ms_tick),
    .grant      (grant),
    .key_state  (key_state),
    .pending    (pending),
    .keep_alive (keep_alive)
  );

  kps_event_arb #(
    .NR (MAX_ROWS),
    .NC (MAX_COLS)
  ) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .pending   (pending),
    .key_state (key_state),
    .grant     (grant),
    .evt_valid (evt_valid),
    .evt_data  (evt_data)
  );

  // R8
  disabled_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pending & ~key_en & ~key_state) == '0))
    else $error("press reported for a disabled key");

  // R9
  idle_cols_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!keep_alive && row_low == '0 && $past(!keep_alive && row_low == '0)
     && $past(col_out) == col_out) |-> (evt_valid == 1'b0))
    else $error("event while quiet");
endmodule

// File: tb/keypad_scanner_test.sv
module keypad_scanner_test;
  localparam int CLK_PERIOD = 10;
  localparam int NR   = 3;
  localparam int NC   = 4;
  localparam int DEB  = 3;
  localparam int SETL = 4;
  localparam int TGAP = 60;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NR-1:0]     row_in;
  logic [1:0]        num_rows = 2'd3;
  logic [2:0]        num_cols = 3'd4;
  logic              ms_tick = 1'b0;
  logic [NC-1:0]     col_out;
  logic              evt_valid;
  logic [7:0]        evt_data;
  logic [NR*NC-1:0]  kmat = '0;

  int checks = 0;
  int fails  = 0;
  int ev_n   = 0;
  int ev_data [0:255];
  int ev_cyc  [0:255];
  int cyc    = 0;
  int walk_viol = 0;
  int scan_cnt  = 0;
  int prev_idx  = -1;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  keypad_scanner #(
    .MAX_ROWS(NR), .MAX_COLS(NC), .DEBOUNCE_MS(DEB), .SETTLE_CYCLES(SETL)
  ) uut (
    .clk(clk), .rst_n(rst_n), .row_in(row_in), .num_rows(num_rows),
    .num_cols(num_cols), .ms_tick(ms_tick), .col_out(col_out),
    .evt_valid(evt_valid), .evt_data(evt_data)
  );

  // Switch matrix: a closed key pulls its row low when its column is low.
  always_comb begin
    for (int r = 0; r < NR; r++) begin
      row_in[r] = 1'b1;
      for (int c = 0; c < NC; c++)
        if (kmat[r*NC + c] && !col_out[c]) row_in[r] = 1'b0;
    end
  end

  function automatic logic [NC-1:0] idle_pat(int nc);
    logic [NC-1:0] p;
    for (int c = 0; c < NC; c++) p[c] = (c >= nc);
    return p;
  endfunction

  function automatic int code_of(int r, int c);
    return r * NC + c + 1;
  endfunction

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && evt_valid && ev_n < 256) begin
      ev_data[ev_n] = int'(evt_data);
      ev_cyc[ev_n]  = cyc;
      ev_n = ev_n + 1;
    end
    if (rst_n) begin
      if (col_out != idle_pat(int'(num_cols))) begin
        int z;
        int idx;
        z = 0; idx = -1;
        scan_cnt = scan_cnt + 1;
        for (int c = 0; c < NC; c++) if (!col_out[c]) begin z++; idx = c; end
        if (z != 1 || idx >= int'(num_cols)) walk_viol++;
        else if (prev_idx == -1) begin
          if (idx != 0) walk_viol++;
        end else if (idx != prev_idx) begin
          if (!(idx == prev_idx + 1 ||
                (prev_idx == int'(num_cols) - 1 && idx == 0))) walk_viol++;
        end
        prev_idx = idx;
      end else begin
        prev_idx = -1;
      end
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick_n(int n);
    repeat (n) begin
      wait_cyc(TGAP - 1);
      ms_tick = 1'b1;
      @(negedge clk);
      ms_tick = 1'b0;
    end
  endtask

  // Press, then release, one key; check debounce boundaries and codes.
  task automatic key_cycle(int r, int c);
    int base;
    int code;
    code = code_of(r, c);
    base = ev_n;
    kmat[r*NC + c] = 1'b1;
    tick_n(DEB - 1);
    check(ev_n == base, "R5", "press event before last tick", ev_n - base, 0);
    tick_n(1);
    wait_cyc(6);
    check(ev_n == base + 1, "R5", "press event count", ev_n - base, 1);
    if (ev_n > base)
      check(ev_data[base] == (128 + code), "R4", "press byte (R6 flag set)",
            ev_data[base], 128 + code);
    base = ev_n;
    kmat[r*NC + c] = 1'b0;
    tick_n(DEB - 1);
    check(ev_n == base, "R6", "release event before last tick", ev_n - base, 0);
    tick_n(1);
    wait_cyc(6);
    check(ev_n == base + 1, "R6", "release event count", ev_n - base, 1);
    if (ev_n > base)
      check(ev_data[base] == code, "R6", "release byte", ev_data[base], code);
    wait_cyc(40);
    check(col_out == idle_pat(int'(num_cols)), "R9", "idle after release",
          int'(col_out), int'(idle_pat(int'(num_cols))));
  endtask

  task automatic dead_key(int r, int c);
    int base;
    int sc;
    base = ev_n;
    sc = scan_cnt;
    kmat[r*NC + c] = 1'b1;
    tick_n(DEB + 1);
    check(ev_n == base, "R8", "event from disabled key", ev_n - base, 0);
    check(scan_cnt == sc, "R2", "scan started by disabled key", scan_cnt - sc, 0);
    kmat[r*NC + c] = 1'b0;
    wait_cyc(10);
  endtask

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(3);
    // R1
    check(col_out == idle_pat(NC), "R1", "reset columns", int'(col_out), 0);
    check(ev_n == 0 && !evt_valid, "R1", "no event after reset", ev_n, 0);
    wait_cyc(30);
    check(col_out == idle_pat(NC), "R2", "idle columns low", int'(col_out), 0);

    // Full matrix, every key.
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++) key_cycle(r, c);

    // R5 bounce restarts the count.
    begin
      int base;
      base = ev_n;
      kmat[1*NC + 2] = 1'b1;
      tick_n(DEB - 1);
      kmat[1*NC + 2] = 1'b0;
      wait_cyc(40);
      kmat[1*NC + 2] = 1'b1;
      tick_n(DEB - 1);
      check(ev_n == base, "R5", "bounce did not restart count", ev_n - base, 0);
      tick_n(1);
      wait_cyc(6);
      check(ev_n == base + 1, "R5", "event after restarted count", ev_n - base, 1);
      kmat[1*NC + 2] = 1'b0;
      tick_n(DEB + 1);
      wait_cyc(40);
    end

    // R7 simultaneous keys, lowest code first on consecutive cycles.
    begin
      int base;
      base = ev_n;
      kmat[2*NC + 3] = 1'b1;
      kmat[0*NC + 1] = 1'b1;
      tick_n(DEB);
      wait_cyc(6);
      check(ev_n == base + 2, "R7", "two press events", ev_n - base, 2);
      if (ev_n >= base + 2) begin
        check(ev_data[base] == 128 + code_of(0, 1), "R7", "first press",
              ev_data[base], 128 + code_of(0, 1));
        check(ev_data[base+1] == 128 + code_of(2, 3), "R7", "second press",
              ev_data[base+1], 128 + code_of(2, 3));
        check(ev_cyc[base+1] == ev_cyc[base] + 1, "R7", "back-to-back strobes",
              ev_cyc[base+1] - ev_cyc[base], 1);
      end
      base = ev_n;
      kmat = '0;
      tick_n(DEB);
      wait_cyc(6);
      check(ev_n == base + 2, "R7", "two release events", ev_n - base, 2);
      if (ev_n >= base + 2) begin
        check(ev_data[base] == code_of(0, 1), "R7", "first release",
              ev_data[base], code_of(0, 1));
        check(ev_data[base+1] == code_of(2, 3), "R7", "second release",
              ev_data[base+1], code_of(2, 3));
      end
      wait_cyc(40);
      check(col_out == idle_pat(NC), "R9", "idle after multi release",
            int'(col_out), 0);
    end

    // Reduced setting: 2 rows, 3 columns.
    num_rows = 2'd2;
    num_cols = 3'd3;
    wait_cyc(10);
    check(col_out == idle_pat(3), "R2", "reduced idle pattern",
          int'(col_out), int'(idle_pat(3)));
    dead_key(2, 1);
    dead_key(0, 3);
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < 3; c++) key_cycle(r, c);

    // R3 column walk across the whole run.
    check(walk_viol == 0, "R3", "column walk violations", walk_viol, 0);
    check(scan_cnt > 0, "R3", "scan cycles observed", scan_cnt, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1-R9 actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule